// File: doc/BRIEF.md
# Strap-Addressed I2C Slave Receiver

This block is the serial front end of a small bus peripheral that is mostly written to. It oversamples SCL and SDA from a fast system clock and finds START, STOP and repeated START conditions. It then shifts in a 7-bit address and a direction bit. Its own address has a fixed upper field of `1001` and a low field taken from three strap inputs, so eight copies can share one bus. An accepted address or data byte is acknowledged by pulling SDA low for the ninth clock. The block only pulls SDA low and never drives it high.

Each received data byte goes to a downstream decoder as a one-cycle strobe. The strobe carries the byte's position in the transaction and a flag for the first byte. When the read-permit input is high, a read request is also acknowledged. The block then serialises bytes, MSB first, from a parallel source. It takes a new byte each time the master acknowledges, and it stops driving when the master answers with NACK.

Top module: `i2c_strap_slave`

## Requirements
- R1: The block acknowledges an address byte only when all seven address bits equal `{1001, strap_i[2:0]}`, with the address sent MSB first.
- R2: After an accepted address or data byte, `sda_pull_o` is 1 while SCL is high for the ninth clock. It returns to 0 after the ninth falling SCL edge unless read data follows.
- R3: Each data byte written after an accepted write address is acknowledged. It is also presented once on `wr_data_o` with a one-cycle `wr_valid_o`. `wr_idx_o` counts 0, 1, 2 and so on within the transaction, and `wr_first_o` is 1 only for index 0.
- R4: With `rd_allow_i` at 0, an address byte with direction bit 1 is not acknowledged and `rd_pop_o` never pulses.
- R5: With `rd_allow_i` at 1, a matching address with direction bit 1 is acknowledged. When that address is accepted, `rd_data_i` is captured and `rd_pop_o` pulses. The captured byte is sent MSB first, and a 0 bit appears as `sda_pull_o` = 1.
- R6: During a read, a master ACK (SDA low on the ninth clock) causes a new capture with a `rd_pop_o` pulse, and that byte is sent next. A master NACK releases SDA, so further clocks read all ones until the next START or STOP.
- R7: After an address that does not match, the block neither acknowledges nor hands off any byte until the next START.
- R8: A STOP ends the transaction, and bytes clocked afterwards without a START are ignored. A repeated START restarts address reception and resets the byte index to 0.
- R9: `sda_pull_o` changes only in the cycle after a detected falling SCL edge, START or STOP, so the line never moves while SCL is high.
- R10: During reset, `sda_pull_o`, `wr_valid_o` and `rd_pop_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = pull SDA low; 0 = release (open drain) |
| strap_i | input | 3 | Low three bits of the device address |
| rd_allow_i | input | 1 | 1 = read requests are acknowledged and served |
| wr_data_o | output | 8 | Last received data byte |
| wr_valid_o | output | 1 | One-cycle strobe for a new data byte |
| wr_idx_o | output | IDX_W | Position of the byte in its transaction, saturating |
| wr_first_o | output | 1 | Byte is the first after the address |
| rd_data_i | input | 8 | Byte to transmit on the next read |
| rd_pop_o | output | 1 | One-cycle pulse: `rd_data_i` was captured |

## Verification
The bench acts as an open-drain bus master. It first sends addresses that differ only in a strap bit, and then only in the fixed upper field. A comparator that drops either field would acknowledge those addresses. A read request is sent with the read permit off, to catch a design that lets direction bit 1 through in write-only mode. The read test ends with a NACK and then clocks one more byte. A design that kept transmitting after the NACK would corrupt that byte, which must read as all ones. A repeated START inside a write must bring the byte index back to 0, and bytes clocked after a STOP without a new START must get no acknowledge and no strobe.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned HI_W    = 4;
  localparam int unsigned STRAP_W = 3;
  localparam int unsigned ADDR_W  = HI_W + STRAP_W;
  localparam int unsigned BIT_CW  = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK_DRV,
    ST_WRITE,
    ST_READ,
    ST_READ_REL,
    ST_READ_MACK,
    ST_READ_NEXT,
    ST_IGNORE
  } slv_state_e;

endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic                   scl_q;
  logic                   sda_q;
  logic                   scl_now;
  logic                   sda_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[LAST];
      sda_q    <= sda_pipe[LAST];
    end
  end

  assign scl_now = scl_pipe[LAST];
  assign sda_now = sda_pipe[LAST];

  always_comb begin
    sda_o      = sda_now;
    scl_rise_o = scl_now & ~scl_q;
    scl_fall_o = ~scl_now & scl_q;
    start_o    = scl_now & scl_q & sda_q & ~sda_now;
    stop_o     = scl_now & scl_q & ~sda_q & sda_now;
  end

endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
  parameter int unsigned     HI_W     = 4,
  parameter int unsigned     STRAP_W  = 3,
  parameter logic [HI_W-1:0] FIXED_HI = 4'b1001
) (
  input  logic [HI_W+STRAP_W-1:0] addr_i,
  input  logic [STRAP_W-1:0]      strap_i,
  output logic                    match_o
);

  localparam int unsigned AW = HI_W + STRAP_W;

  logic [AW-1:0] own;
  logic [AW-1:0] bit_eq;

  assign own = {FIXED_HI, strap_i};

  for (genvar g = 0; g < AW; g++) begin : g_bit
    assign bit_eq[g] = ~(addr_i[g] ^ own[g]);
  end

  assign match_o = &bit_eq;

endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
  import i2c_strap_pkg::*;
#(
  parameter int unsigned     IDX_W       = 4,
  parameter int unsigned     SYNC_STAGES = 2,
  parameter logic [HI_W-1:0] FIXED_HI    = 4'b1001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [2:0]         strap_i,
  input  logic               rd_allow_i,
  output logic [7:0]         wr_data_o,
  output logic               wr_valid_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic               wr_first_o,
  input  logic [7:0]         rd_data_i,
  output logic               rd_pop_o
);

  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);
  localparam logic [IDX_W-1:0]  IDX_MAX  = '1;

  // bus conditions
  logic sda_s;
  logic scl_rise;
  logic scl_fall;
  logic start_det;
  logic stop_det;

  i2c_bus_cond #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  // state
  slv_state_e         state_q, state_d;
  logic [BIT_CW-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0]  sh_q, sh_d;
  logic [BYTE_W-1:0]  tx_q, tx_d;
  logic               pull_q, pull_d;
  logic               is_rd_q, is_rd_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [BYTE_W-1:0]  wdat_q, wdat_d;
  logic               wval_q, wval_d;
  logic [IDX_W-1:0]   widx_q, widx_d;
  logic               wfst_q, wfst_d;
  logic               pop_q, pop_d;
  logic               addr_hit;

  i2c_addr_cmp #(
    .HI_W     (HI_W),
    .STRAP_W  (STRAP_W),
    .FIXED_HI (FIXED_HI)
  ) u_cmp (
    .addr_i  (sh_q),
    .strap_i (strap_i),
    .match_o (addr_hit)
  );

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    pull_d  = pull_q;
    is_rd_d = is_rd_q;
    idx_d   = idx_q;
    wdat_d  = wdat_q;
    widx_d  = widx_q;
    wfst_d  = wfst_q;
    wval_d  = 1'b0;
    pop_d   = 1'b0;

    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
      idx_d   = '0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
        end

        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[ADDR_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              if (addr_hit && (!sda_s || rd_allow_i)) begin
                state_d = ST_ACK_WAIT;
                is_rd_d = sda_s;
                if (sda_s) begin
                  tx_d  = rd_data_i;
                  pop_d = 1'b1;
                end
              end else begin
                state_d = ST_IGNORE;
              end
            end
          end
        end

        ST_ACK_WAIT: begin
          if (scl_fall) begin
            pull_d  = 1'b1;
            state_d = ST_ACK_DRV;
          end
        end

        ST_ACK_DRV: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (is_rd_q) begin
              pull_d  = ~tx_q[BYTE_W-1];
              state_d = ST_READ;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_WRITE;
            end
          end
        end

        ST_WRITE: begin
          if (scl_rise) begin
            sh_d  = {sh_q[ADDR_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              wdat_d  = {sh_q, sda_s};
              wval_d  = 1'b1;
              widx_d  = idx_q;
              wfst_d  = (idx_q == '0);
              if (idx_q != IDX_MAX) begin
                idx_d = idx_q + 1'b1;
              end
              state_d = ST_ACK_WAIT;
            end
          end
        end

        ST_READ: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              state_d = ST_READ_REL;
            end
          end else if (scl_fall) begin
            pull_d = ~tx_q[LAST_BIT - cnt_q];
          end
        end

        ST_READ_REL: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            state_d = ST_READ_MACK;
          end
        end

        ST_READ_MACK: begin
          if (scl_rise) begin
            if (!sda_s) begin
              tx_d    = rd_data_i;
              pop_d   = 1'b1;
              state_d = ST_READ_NEXT;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end

        ST_READ_NEXT: begin
          if (scl_fall) begin
            pull_d  = ~tx_q[BYTE_W-1];
            cnt_d   = '0;
            state_d = ST_READ;
          end
        end

        ST_IGNORE: begin
        end

        default: begin
          state_d = ST_IDLE;
          pull_d  = 1'b0;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      pull_q  <= 1'b0;
      is_rd_q <= 1'b0;
      idx_q   <= '0;
      wdat_q  <= '0;
      wval_q  <= 1'b0;
      widx_q  <= '0;
      wfst_q  <= 1'b0;
      pop_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      pull_q  <= pull_d;
      is_rd_q <= is_rd_d;
      idx_q   <= idx_d;
      wdat_q  <= wdat_d;
      wval_q  <= wval_d;
      widx_q  <= widx_d;
      wfst_q  <= wfst_d;
      pop_q   <= pop_d;
    end
  end

  assign sda_pull_o = pull_q;
  assign wr_data_o  = wdat_q;
  assign wr_valid_o = wval_q;
  assign wr_idx_o   = widx_q;
  assign wr_first_o = wfst_q;
  assign rd_pop_o   = pop_q;

endmodule

// File: rtl/i2c_strap_slave_chk.sv
module i2c_strap_slave_chk
  import i2c_strap_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_pull,
  input logic       wr_valid,
  input logic       rd_pop,
  input logic       rd_allow,
  input slv_state_e state
);

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_pull && state == ST_ADDR)); // R8

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_pull && state == ST_IDLE)); // R8

  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> (!sda_pull && !wr_valid && !rd_pop)); // R7

  AST_NO_POP_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_allow && $stable(rd_allow)) |-> !rd_pop); // R4

  AST_WR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R3

  AST_PULL_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(scl_fall) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_pull)); // R9

endmodule

bind i2c_strap_slave i2c_strap_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_pull  (sda_pull_o),
  .wr_valid  (wr_valid_o),
  .rd_pop    (rd_pop_o),
  .rd_allow  (rd_allow_i),
  .state     (state_q)
);

// File: tb/test_i2c_strap_slave.sv
`timescale 1ns/1ps
module test_i2c_strap_slave;

  localparam int Q = 10;
  localparam int H = 20;
  localparam int IDX_W = 4;

  logic             clk;
  logic             rst_n;
  logic             m_scl;
  logic             m_sda;
  logic             sda_line;
  logic             sda_pull_o;
  logic [2:0]       strap_i;
  logic             rd_allow_i;
  logic [7:0]       wr_data_o;
  logic             wr_valid_o;
  logic [IDX_W-1:0] wr_idx_o;
  logic             wr_first_o;
  logic [7:0]       rd_data_i;
  logic             rd_pop_o;

  int n_run;
  int n_fail;
  int pop_cnt;
  int wcnt;
  logic [7:0]       wlog_data [16];
  logic [IDX_W-1:0] wlog_idx  [16];
  logic             wlog_fst  [16];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull_o;

  function automatic logic [7:0] src_val(input int k);
    return 8'(8'h5A + k * 8'h37);
  endfunction

  assign rd_data_i = src_val(pop_cnt);

  i2c_strap_slave #(.IDX_W(IDX_W)) i_i2c_strap_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull_o),
    .strap_i    (strap_i),
    .rd_allow_i (rd_allow_i),
    .wr_data_o  (wr_data_o),
    .wr_valid_o (wr_valid_o),
    .wr_idx_o   (wr_idx_o),
    .wr_first_o (wr_first_o),
    .rd_data_i  (rd_data_i),
    .rd_pop_o   (rd_pop_o)
  );

  always @(negedge clk) begin
    if (rd_pop_o) pop_cnt = pop_cnt + 1;
    if (wr_valid_o) begin
      if (wcnt < 16) begin
        wlog_data[wcnt] = wr_data_o;
        wlog_idx[wcnt]  = wr_idx_o;
        wlog_fst[wcnt]  = wr_first_o;
      end
      wcnt = wcnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wclk(Q);
    m_scl = 1'b1; wclk(H);
    m_sda = 1'b0; wclk(H);
    m_scl = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wclk(Q);
    m_scl = 1'b1; wclk(H);
    m_sda = 1'b1; wclk(H);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wclk(Q);
    m_scl = 1'b1; wclk(H);
    m_scl = 1'b0; wclk(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wclk(Q);
    m_scl = 1'b1; wclk(H/2);
    acked = !sda_line;
    wclk(H/2);
    m_scl = 1'b0; wclk(Q);
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] d, output bit steady);
    logic p0;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wclk(Q);
      m_scl = 1'b1; wclk(H/2);
      p0 = sda_line;
      d[i] = p0;
      wclk(H/2 - 1);
      if (sda_line !== p0) steady = 1'b0;
      wclk(1);
      m_scl = 1'b0; wclk(Q);
    end
    send_bit(!mack);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wclk(5);
    check(sda_pull_o == 1'b0, "R10", "pull in reset", sda_pull_o, 0);
    check(wr_valid_o == 1'b0 && rd_pop_o == 1'b0, "R10", "strobes in reset",
          {wr_valid_o, rd_pop_o}, 0);
    rst_n = 1'b1;
    wclk(5);
  endtask

  task automatic t_write();
    bit a;
    int base;
    logic [7:0] pay [3];
    pay[0] = 8'hC3; pay[1] = 8'h7E; pay[2] = 8'h01;
    strap_i = 3'b101; rd_allow_i = 1'b0;
    base = wcnt;
    bus_start();
    write_byte({7'b1001101, 1'b0}, a);
    check(a, "R1", "matching address ack", a, 1);
    check(sda_pull_o == 1'b0, "R2", "ack released after ninth clock", sda_pull_o, 0);
    for (int i = 0; i < 3; i++) begin
      write_byte(pay[i], a);
      check(a, "R3", "data byte ack", a, 1);
    end
    bus_stop();
    check(wcnt == base + 3, "R3", "byte strobes", wcnt - base, 3);
    for (int i = 0; i < 3; i++) begin
      check(wlog_data[base+i] == pay[i], "R3", "byte value", wlog_data[base+i], pay[i]);
      check(wlog_idx[base+i] == IDX_W'(i) && wlog_fst[base+i] == (i == 0), "R3",
            "index and first flag", {wlog_fst[base+i], wlog_idx[base+i]},
            {(i == 0), IDX_W'(i)});
    end
  endtask

  task automatic t_mismatch();
    bit a;
    int base;
    strap_i = 3'b101; rd_allow_i = 1'b0;
    base = wcnt;
    bus_start();
    write_byte({7'b1001100, 1'b0}, a);
    check(!a, "R1", "strap bit differs, no ack", a, 0);
    write_byte(8'hFF, a);
    check(!a, "R7", "byte after mismatch, no ack", a, 0);
    check(wcnt == base, "R7", "no strobe after mismatch", wcnt - base, 0);
    bus_start();
    write_byte({7'b0001101, 1'b0}, a);
    check(!a, "R1", "fixed field differs, no ack", a, 0);
    bus_stop();
  endtask

  task automatic t_read_write_only();
    bit a;
    int base;
    strap_i = 3'b101; rd_allow_i = 1'b0;
    base = pop_cnt;
    bus_start();
    write_byte({7'b1001101, 1'b1}, a);
    check(!a, "R4", "read refused in write-only mode", a, 0);
    check(pop_cnt == base, "R4", "no capture", pop_cnt - base, 0);
    bus_stop();
  endtask

  task automatic t_read();
    bit a;
    bit s;
    int base;
    logic [7:0] d;
    strap_i = 3'b010; rd_allow_i = 1'b1;
    wclk(4);
    base = pop_cnt;
    bus_start();
    write_byte({7'b1001010, 1'b1}, a);
    check(a, "R5", "read address ack", a, 1);
    check(pop_cnt == base + 1, "R5", "first capture", pop_cnt - base, 1);
    read_byte(1'b1, d, s);
    check(d == src_val(base), "R5", "first read byte", d, src_val(base));
    check(s, "R9", "line steady while SCL high", s, 1);
    read_byte(1'b1, d, s);
    check(d == src_val(base + 1), "R6", "byte after master ack", d, src_val(base + 1));
    read_byte(1'b0, d, s);
    check(d == src_val(base + 2), "R6", "last byte before nack", d, src_val(base + 2));
    check(s, "R9", "line steady while SCL high", s, 1);
    read_byte(1'b1, d, s);
    check(d == 8'hFF, "R6", "released after nack", d, 8'hFF);
    check(pop_cnt == base + 3, "R6", "captures", pop_cnt - base, 3);
    bus_stop();
    check(sda_pull_o == 1'b0, "R8", "released after stop", sda_pull_o, 0);
    rd_allow_i = 1'b0;
    wclk(4);
  endtask

  task automatic t_restart();
    bit a;
    int base;
    strap_i = 3'b101; rd_allow_i = 1'b0;
    bus_start();
    write_byte({7'b1001101, 1'b0}, a);
    write_byte(8'hA1, a);
    bus_start();
    write_byte({7'b1001101, 1'b0}, a);
    check(a, "R8", "address after repeated start", a, 1);
    base = wcnt;
    write_byte(8'h4B, a);
    check(wcnt == base + 1 && wlog_data[base] == 8'h4B, "R8", "byte after restart",
          wlog_data[base], 8'h4B);
    check(wlog_idx[base] == '0 && wlog_fst[base], "R8", "index reset by restart",
          {wlog_fst[base], wlog_idx[base]}, {1'b1, IDX_W'(0)});
    bus_stop();
    m_scl = 1'b0; wclk(Q);
    base = wcnt;
    write_byte(8'h99, a);
    check(!a, "R8", "no ack after stop", a, 0);
    check(wcnt == base, "R8", "no strobe after stop", wcnt - base, 0);
    m_sda = 1'b1; wclk(Q);
    m_scl = 1'b1; wclk(H);
  endtask

  initial begin
    n_run = 0; n_fail = 0; pop_cnt = 0; wcnt = 0;
    m_scl = 1'b1; m_sda = 1'b1;
    strap_i = 3'b101; rd_allow_i = 1'b0;
    rst_n = 1'b0;
    t_reset();
    t_write();
    t_mismatch();
    t_read_write_only();
    t_read();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule